// File: doc/BRIEF.md
# Horizontal sync regenerator

This block takes the raw horizontal sync of an incoming video stream, which can arrive with either polarity and without any relation to the pixel clock, and turns it into a clean sync pulse in the pixel clock domain. The pulse is ready for downstream display logic. The block measures how long the sync input stays high and how long it stays low. The shorter of the two levels is taken as the active sync level. The block then starts one output pulse on each active edge of the sync input. The pulse has a programmed width in pixel clocks, and its output polarity is selectable.

A pixel data word travels through a delay line whose depth matches the sync path. The sync pulse and the data leave the block aligned on the same clock cycle. A coast input has its own polarity setting. While coast is active, the block ignores the edges of the sync input: no pulse starts and the polarity measurement is paused. This protects downstream timing from the disturbed sync that occurs during vertical blanking.

Top module: `hsync_regen`

## Requirements
- R1: While reset is asserted, `hsync_o` sits at its inactive level (the inverse of `out_act_high_i`), `in_pol_o` is 0 and `data_o` is 0.
- R2: `in_pol_o` reports the detected input polarity (1 = active high, 0 = active low). After two complete sync levels have been seen outside coast, it equals 1 when the high time is shorter than the low time, and 0 when the low time is shorter. When the two times are equal, it keeps its value.
- R3: An active edge of `hsync_i` (a rising edge when `in_pol_o` is 1, a falling edge when it is 0) drives `hsync_o` to its active level. This happens on the third rising clock edge, counting the first edge that samples the new input level. The inactive edge starts no pulse.
- R4: A pulse started with `width_i` = W (1 to 255) stays active for exactly W clock cycles. `width_i` is sampled on the cycle the pulse starts.
- R5: A pulse started with `width_i` = 0 lasts exactly one clock cycle.
- R6: With `out_act_high_i` = 1 the active level of `hsync_o` is 1. With `out_act_high_i` = 0 the active level is 0, and the output idles high.
- R7: Coast is active when the synchronized `coast_i` equals `coast_act_high_i`. While coast is active, sync edges start no pulse.
- R8: While coast is active, `in_pol_o` does not change. The first partial sync level after coast ends is not used for the measurement.
- R9: `data_o` equals the `data_i` value sampled three clock edges earlier. This is the same latency that R3 gives the sync path.
- R10: An active edge that arrives while a pulse is running restarts the width count. The pulse then ends W cycles after the restart, with no inactive gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Raw horizontal sync, asynchronous, either polarity |
| coast_i | input | 1 | Coast request, asynchronous |
| coast_act_high_i | input | 1 | 1: coast active when `coast_i` is high; 0: active when low |
| out_act_high_i | input | 1 | Output sync polarity select, 1 = active high |
| width_i | input | WID_W (8) | Output pulse width in pixel clocks (0 gives one clock) |
| data_i | input | DATA_W (24) | Pixel data word |
| hsync_o | output | 1 | Regenerated sync pulse |
| data_o | output | DATA_W (24) | Pixel data aligned with `hsync_o` |
| in_pol_o | output | 1 | Detected input sync polarity, 1 = active high |

## Verification
An input edge applied just after a falling clock edge reaches `hsync_o` three rising edges later. The bench records that cycle index and compares it with the drive cycle plus three. It measures each pulse length at the falling clock edge and compares it with the width rule. Data words are checked against a four-entry history three cycles behind. Polarity and coast outcomes are read only after several complete lines, and pulse counts are read only after the pulse has certainly finished, so no check falls on a transition cycle.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  // Edge information about the synchronized sync level.
  typedef struct packed {
    logic rise;
    logic fall;
  } hsr_edge_t;

  // Encoding of a detected polarity.
  typedef enum logic {
    POL_ACT_LOW  = 1'b0,
    POL_ACT_HIGH = 1'b1
  } hsr_pol_e;

endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/hsr_pol_detect.sv
module hsr_pol_detect
  import hsr_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hold_i,
  input  hsr_edge_t edge_i,
  output logic      pol_o
);

  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] hi_len_q, hi_len_d;
  logic [CNT_W-1:0] lo_len_q, lo_len_d;
  logic             hi_vld_q, hi_vld_d;
  logic             lo_vld_q, lo_vld_d;
  logic             skip_q, skip_d;
  hsr_pol_e         pol_q, pol_d;

  always_comb begin
    run_d    = run_q;
    hi_len_d = hi_len_q;
    lo_len_d = lo_len_q;
    hi_vld_d = hi_vld_q;
    lo_vld_d = lo_vld_q;
    skip_d   = skip_q;
    pol_d    = pol_q;
    if (hold_i) begin
      // Measurement paused; the level that is running is partial.
      run_d    = '0;
      hi_vld_d = 1'b0;
      lo_vld_d = 1'b0;
      skip_d   = 1'b1;
    end else if (edge_i.rise || edge_i.fall) begin
      run_d  = CNT_W'(1);
      skip_d = 1'b0;
      if (!skip_q) begin
        if (edge_i.rise) begin
          lo_len_d = run_q;
          lo_vld_d = 1'b1;
          if (hi_vld_q && (hi_len_q != run_q)) begin
            pol_d = (hi_len_q < run_q) ? POL_ACT_HIGH : POL_ACT_LOW;
          end
        end else begin
          hi_len_d = run_q;
          hi_vld_d = 1'b1;
          if (lo_vld_q && (lo_len_q != run_q)) begin
            pol_d = (run_q < lo_len_q) ? POL_ACT_HIGH : POL_ACT_LOW;
          end
        end
      end
    end else if (run_q != RUN_MAX) begin
      run_d = run_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      hi_len_q <= '0;
      lo_len_q <= '0;
      hi_vld_q <= 1'b0;
      lo_vld_q <= 1'b0;
      skip_q   <= 1'b1;
      pol_q    <= POL_ACT_LOW;
    end else begin
      run_q    <= run_d;
      hi_len_q <= hi_len_d;
      lo_len_q <= lo_len_d;
      hi_vld_q <= hi_vld_d;
      lo_vld_q <= lo_vld_d;
      skip_q   <= skip_d;
      pol_q    <= pol_d;
    end
  end

  assign pol_o = (pol_q == POL_ACT_HIGH);

endmodule

// File: rtl/hsr_pulse_gen.sv
module hsr_pulse_gen #(
  parameter int unsigned WID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WID_W-1:0] width_i,
  output logic             active_o
);

  logic [WID_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             act_q, act_d;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start_i) begin
      cnt_d = (width_i == '0) ? WID_W'(1) : width_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - WID_W'(1);
    end
    act_d = (cnt_d != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/hsr_delay.sv
module hsr_delay #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [DEPTH-1:0][WIDTH-1:0] pipe_q;
  logic [DEPTH-1:0][WIDTH-1:0] pipe_d;

  if (DEPTH == 1) begin : g_single
    always_comb begin
      pipe_d[0] = d_i;
    end
  end else begin : g_chain
    always_comb begin
      pipe_d = {pipe_q[DEPTH-2:0], d_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign q_o = pipe_q[DEPTH-1];

endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
  import hsr_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned WID_W       = 8,
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              coast_i,
  input  logic              coast_act_high_i,
  input  logic              out_act_high_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hsync_o,
  output logic [DATA_W-1:0] data_o,
  output logic              in_pol_o
);

  // Sync path: SYNC_STAGES flops, one edge compare, one output flop.
  localparam int unsigned ALIGN_DEPTH = SYNC_STAGES + 1;
  localparam int unsigned N_ASYNC     = 2;

  logic [N_ASYNC-1:0] async_w;
  logic [N_ASYNC-1:0] sync_w;
  logic               hs_s;
  logic               coast_s;
  logic               hs_prev_q, hs_prev_d;
  hsr_edge_t          edge_w;
  logic               coast_w;
  logic               start_w;
  logic               act_w;

  assign async_w = {coast_i, hsync_i};

  hsr_sync #(
    .WIDTH (N_ASYNC),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(async_w),
    .sync_o (sync_w)
  );

  assign hs_s    = sync_w[0];
  assign coast_s = sync_w[1];

  always_comb begin
    hs_prev_d   = hs_s;
    edge_w.rise = hs_s && !hs_prev_q;
    edge_w.fall = !hs_s && hs_prev_q;
    coast_w     = (coast_s == coast_act_high_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_prev_q <= 1'b0;
    end else begin
      hs_prev_q <= hs_prev_d;
    end
  end

  hsr_pol_detect #(
    .CNT_W(CNT_W)
  ) u_pol (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(coast_w),
    .edge_i(edge_w),
    .pol_o (in_pol_o)
  );

  always_comb begin
    start_w = !coast_w && (in_pol_o ? edge_w.rise : edge_w.fall);
  end

  hsr_pulse_gen #(
    .WID_W(WID_W)
  ) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .width_i (width_i),
    .active_o(act_w)
  );

  assign hsync_o = act_w ? out_act_high_i : !out_act_high_i;

  hsr_delay #(
    .WIDTH(DATA_W),
    .DEPTH(ALIGN_DEPTH)
  ) u_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (data_i),
    .q_o   (data_o)
  );

endmodule

// File: rtl/hsync_regen_chk.sv
module hsync_regen_chk #(
  parameter int unsigned WID_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             act_i,
  input logic             coast_i,
  input logic             pol_i,
  input logic [WID_W-1:0] width_i
);

  logic [WID_W:0] exp_q;
  logic [WID_W:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      len_q <= '0;
    end else if (start_i) begin
      exp_q <= (width_i == '0) ? (WID_W+1)'(1) : {1'b0, width_i};
      len_q <= (WID_W+1)'(1);
    end else if (act_i) begin
      len_q <= len_q + (WID_W+1)'(1);
    end
  end

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> act_i);

  p_rise_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_i) |-> $past(start_i));

  p_width_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !start_i && (len_q < exp_q)) |=> act_i);

  p_width_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !start_i && (len_q == exp_q)) |=> !act_i);

  p_zero_one_clk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (width_i == '0)) ##1 !start_i |=> !act_i);

  p_coast_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coast_i |-> !start_i);

  p_pol_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coast_i |=> $stable(pol_i));

endmodule

bind hsync_regen hsync_regen_chk #(.WID_W(WID_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_w),
  .act_i  (act_w),
  .coast_i(coast_w),
  .pol_i  (in_pol_o),
  .width_i(width_i)
);

// File: tb/tb_hsync_regen.sv
module tb_hsync_regen;
  localparam int DW = 24;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hs_in, co_in, co_hi, out_hi;
  logic [WW-1:0] wid;
  logic [DW-1:0] din;
  logic          hs_out;
  logic [DW-1:0] dout;
  logic          pol;

  hsync_regen #(.DATA_W(DW), .WID_W(WW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs_in), .coast_i(co_in),
    .coast_act_high_i(co_hi), .out_act_high_i(out_hi), .width_i(wid),
    .data_i(din), .hsync_o(hs_out), .data_o(dout), .in_pol_o(pol));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  bit data_run = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic int exp_start(input int drv);
    return drv + 3;
  endfunction

  // Pulse monitor, sampled at the falling clock edge.
  int last_start = 0, last_len = 0, n_pulses = 0, run_len = 0;
  bit prev_a = 1'b0, cur_a;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_a = 1'b0;
    end else begin
      cur_a = (hs_out == out_hi);
      if (cur_a && !prev_a) begin
        last_start = cyc;
        run_len = 1;
      end else if (cur_a) begin
        run_len++;
      end
      if (!cur_a && prev_a) begin
        last_len = run_len;
        n_pulses++;
      end
      prev_a = cur_a;
    end
  end

  // Data stimulus and alignment check (R9).
  logic [DW-1:0] hist [4];
  initial begin
    int seen;
    seen = 0;
    din = '0;
    wait (data_run);
    while (data_run) begin
      @(negedge clk);
      if (seen >= 3)
        check(dout == hist[(cyc + 1) % 4], "R9", "data_o",
              dout, hist[(cyc + 1) % 4]);
      din = DW'($urandom);
      hist[cyc % 4] = din;
      seen++;
    end
  end

  task automatic run_line(input bit act_hi, input int sync_len, input int gap_len,
                          input int w, input bit chk, input bit expect_pulse,
                          input string wreq);
    int base, drv;
    @(negedge clk);
    wid = WW'(w);
    base = n_pulses;
    hs_in = act_hi;
    drv = cyc;
    repeat (sync_len) @(negedge clk);
    hs_in = !act_hi;
    repeat (gap_len) @(negedge clk);
    #1;
    if (chk) begin
      if (expect_pulse) begin
        check(n_pulses == base + 1, "R3", "pulse count", n_pulses - base, 1);
        check(last_start == exp_start(drv), "R3", "pulse start cycle",
              last_start, exp_start(drv));
        check(last_len == exp_len(w), wreq, "pulse length", last_len, exp_len(w));
      end else begin
        check(n_pulses == base, "R7", "pulses under coast", n_pulses - base, 0);
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base, drv, cur, ip;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; hs_in = 1'b1; co_in = 1'b0; co_hi = 1'b1; out_hi = 1'b0; wid = 8'd8;
    idle(4);
    // R1: reset state, both output polarities
    check(hs_out == 1'b1, "R1", "hsync_o in reset, active low", hs_out, 1);
    check(pol == 1'b0, "R1", "in_pol_o in reset", pol, 0);
    check(dout == '0, "R1", "data_o in reset", dout, 0);
    out_hi = 1'b1;
    idle(1);
    check(hs_out == 1'b0, "R1", "hsync_o in reset, active high", hs_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    data_run = 1'b1;
    idle(20);

    // R3/R4: active-low input lines
    for (int i = 0; i < 4; i++) run_line(1'b0, 8, 40, 8, 1'b1, 1'b1, "R4");
    check(pol == 1'b0, "R2", "active-low detection", pol, 0);
    run_line(1'b0, 6, 40, 0, 1'b1, 1'b1, "R5");
    run_line(1'b0, 6, 40, 1, 1'b1, 1'b1, "R4");
    run_line(1'b0, 10, 300, 255, 1'b1, 1'b1, "R4");

    // R6: active-low output
    out_hi = 1'b0;
    idle(2);
    check(hs_out == 1'b1, "R6", "idle level, active-low output", hs_out, 1);
    run_line(1'b0, 8, 40, 12, 1'b1, 1'b1, "R6");
    out_hi = 1'b1;
    idle(2);
    check(hs_out == 1'b0, "R6", "idle level, active-high output", hs_out, 0);

    // R10: retrigger during a running pulse
    @(negedge clk);
    wid = 8'd100; base = n_pulses; hs_in = 1'b0; drv = cyc;
    repeat (5) @(negedge clk); hs_in = 1'b1;
    repeat (45) @(negedge clk); hs_in = 1'b0;
    repeat (5) @(negedge clk); hs_in = 1'b1;
    idle(200);
    check(n_pulses == base + 1, "R10", "merged pulse count", n_pulses - base, 1);
    check(last_start == exp_start(drv), "R10", "merged start", last_start, exp_start(drv));
    check(last_len == 150, "R10", "merged length", last_len, 150);

    // R7: coast, active high then active low
    @(negedge clk); co_in = 1'b1;
    idle(4);
    run_line(1'b0, 8, 40, 8, 1'b1, 1'b0, "R7");
    @(negedge clk); co_in = 1'b0;
    idle(4);
    run_line(1'b0, 8, 40, 8, 1'b1, 1'b1, "R7");
    @(negedge clk); co_in = 1'b1;
    idle(4);
    @(negedge clk); co_hi = 1'b0;
    idle(4);
    run_line(1'b0, 8, 40, 8, 1'b1, 1'b1, "R7");
    @(negedge clk); co_in = 1'b0;
    idle(4);
    run_line(1'b0, 8, 40, 8, 1'b1, 1'b0, "R7");
    @(negedge clk); co_in = 1'b1;
    idle(4);

    // R2: switch to active-high input
    @(negedge clk); hs_in = 1'b0;
    idle(80);
    for (int i = 0; i < 3; i++) run_line(1'b1, 8, 60, 8, 1'b0, 1'b1, "R4");
    check(pol == 1'b1, "R2", "active-high detection", pol, 1);
    for (int i = 0; i < 3; i++) run_line(1'b1, 8, 60, 20, 1'b1, 1'b1, "R4");

    // R8: polarity frozen under coast, detection resumes after
    @(negedge clk); co_in = 1'b0;
    idle(4);
    @(negedge clk); hs_in = 1'b1;
    idle(60);
    for (int i = 0; i < 3; i++) run_line(1'b0, 8, 60, 8, 1'b1, 1'b0, "R7");
    check(pol == 1'b1, "R8", "polarity held under coast", pol, 1);
    @(negedge clk); co_in = 1'b1;
    idle(4);
    for (int i = 0; i < 3; i++) run_line(1'b0, 8, 60, 8, 1'b0, 1'b1, "R4");
    check(pol == 1'b0, "R8", "detection after coast", pol, 0);
    cur = 0;

    // Random phases
    for (int ph = 0; ph < 8; ph++) begin
      ip = int'($urandom % 2);
      if (ip != cur) begin
        @(negedge clk); hs_in = (ip == 0);
        idle(80);
        for (int i = 0; i < 3; i++) run_line(ip[0], 8, 60, 8, 1'b0, 1'b1, "R4");
        cur = ip;
      end
      check(pol == ip[0], "R2", "random phase polarity", pol, ip);
      for (int ln = 0; ln < 6; ln++) begin
        @(negedge clk); out_hi = 1'($urandom % 2);
        run_line(ip[0], 2 + int'($urandom % 19), 50 + int'($urandom % 51),
                 int'($urandom % 41), 1'b1, 1'b1, "R4");
      end
    end

    data_run = 1'b0;
    idle(2);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule